// File: doc/BRIEF.md
# Multi-Channel Scan Conversion Sequencer

This block drives one shared analog-to-digital converter across up to 32 inputs. A channel mask picks which inputs take part. After a start pulse the sequencer walks the set bits of the mask from the lowest channel number to the highest. For each channel it launches one conversion on a start/done handshake, and it returns each result together with the number of the channel it came from.

Two levels of single-shot priority request can cut into a running scan at the boundary between two conversions. The scan then carries on where it left off. A repeat control makes the scan loop over the mask. Clearing that control lets the current pass finish before the scan stops. A forced stop drops all activity at once.

Completion flags for scans and for priority conversions each drive an interrupt output, gated by an enable.

Top module: `adc_scan_seq`

## Requirements
- R1: With repeat off, a scan converts each channel whose mask bit is 1, once, in ascending channel order. Each result appears as a one-cycle `res_valid` pulse carrying the 12-bit converter data, the 5-bit channel number on `res_chan`, and `res_src` = 2'b00 (scan).
- R2: While `repeat_en` is 1, after the highest enabled channel completes, the scan starts again from the lowest enabled channel, and `scan_busy` stays 1.
- R3: If `repeat_en` is cleared during a pass, the remaining enabled channels of that pass are still converted. Then `scan_busy` falls to 0, `scan_flag` becomes 1, and no further scan conversion starts.
- R4: A `force_stop` pulse clears `scan_busy`, `prio_busy` and `prio_pend` by the next cycle. No result is delivered for the conversion it cuts off, and nothing further is launched.
- R5: A priority request made during a scan is served at the next conversion boundary. The scan then resumes at the next enabled channel above the last scan channel that completed. Priority results carry `res_src` = 2'b01 for level 1 and 2'b10 for level 2.
- R6: When requests of both levels are pending at a boundary, the level-2 request is converted first.
- R7: `prio_busy` is 1 while a priority conversion of either level is executing, and `conv_start` only pulses while `scan_busy` or `prio_busy` is 1.
- R8: A start pulse while the mask is all zero launches no conversion, leaves `scan_busy` at 0, and sets `scan_flag` one cycle later.
- R9: `scan_irq` equals `scan_ie` AND `scan_flag`, and `prio_irq` equals `prio_ie` AND `prio_flag`. `prio_flag` is set when a priority conversion completes. Each flag is cleared by its clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_mask | input | 32 | One enable bit per channel |
| scan_start | input | 1 | Start pulse; ignored while a scan is busy |
| repeat_en | input | 1 | Loop over the mask while set |
| force_stop | input | 1 | Abort all conversion activity |
| prio1_req | input | 1 | Level-1 priority request pulse |
| prio1_chan | input | 5 | Channel for level 1 |
| prio2_req | input | 1 | Level-2 priority request pulse |
| prio2_chan | input | 5 | Channel for level 2 |
| scan_ie | input | 1 | Scan interrupt enable |
| prio_ie | input | 1 | Priority interrupt enable |
| scan_flag_clr | input | 1 | Clears the scan flag |
| prio_flag_clr | input | 1 | Clears the priority flag |
| conv_start | output | 1 | Convert request pulse to the converter |
| conv_chan | output | 5 | Channel for the convert request |
| conv_abort | output | 1 | Cancels the conversion in flight |
| conv_done | input | 1 | Converter finished |
| conv_data | input | 12 | Converter result |
| res_valid | output | 1 | Result pulse |
| res_data | output | 12 | Result value |
| res_chan | output | 5 | Result channel tag |
| res_src | output | 2 | 00 scan, 01 level 1, 10 level 2 |
| scan_busy | output | 1 | Scan in progress |
| prio_busy | output | 1 | Priority conversion executing |
| prio_pend | output | 1 | Priority request waiting |
| scan_flag | output | 1 | Scan pass finished |
| prio_flag | output | 1 | Priority conversion finished |
| scan_irq | output | 1 | Gated scan interrupt |
| prio_irq | output | 1 | Gated priority interrupt |

## Verification
Four mask patterns exercise the channel walk, and each separates a different fault:
- A sparse mask with bits at both ends (channels 1, 4, 17, 31) shows whether the walk skips zero bits and reaches channel 31.
- An all-zero mask separates a true empty completion from a scan that hangs or spins.
- A two-channel mask under repeat tells a wrap to the lowest channel apart from a stop, and then shows that clearing repeat still finishes the pass.
- An all-ones mask, stopped in the middle of its walk, shows whether pending and in-flight work is dropped.

A scan with both priority levels raised during its first conversion tells level order apart and checks that the scan resumes at the right channel.

// File: rtl/adc_scan_seq_pkg.sv
package adc_scan_seq_pkg;

  // Source of a conversion, also the encoding of res_src
  typedef enum logic [1:0] {
    SRC_SCAN = 2'b00,
    SRC_LV1  = 2'b01,
    SRC_LV2  = 2'b10
  } src_e;

endpackage

// File: rtl/adc_chan_pick.sv
// Finds the lowest enabled channel at or above a start index.
module adc_chan_pick #(
  parameter int NCH = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CHW:0]   from,
  output logic           found,
  output logic [CHW-1:0] idx
);

  // Keep only bits at or above 'from'; from == NCH leaves nothing
  function automatic logic [NCH-1:0] clip_below(input logic [NCH-1:0] m,
                                                 input logic [CHW:0]   f);
    logic [NCH-1:0] low;
    low = (NCH'(1) << f) - NCH'(1);
    if (f >= (CHW+1)'(NCH)) low = '1;
    return m & ~low;
  endfunction

  logic [NCH-1:0] masked;

  always_comb begin
    masked = clip_below(mask, from);
    found  = |masked;
    idx    = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (masked[i]) idx = CHW'(i);
    end
  end

endmodule

// File: rtl/adc_prio_hold.sv
// Holds one pending priority request per level.
module adc_prio_hold #(
  parameter int NCH  = 32,
  parameter int NLVL = 2,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [NLVL-1:0]           req,
  input  logic [NLVL-1:0][CHW-1:0]  req_chan,
  input  logic [NLVL-1:0]           take,
  output logic [NLVL-1:0]           pend,
  output logic [NLVL-1:0][CHW-1:0]  pend_chan
);

  for (genvar lv = 0; lv < NLVL; lv++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        pend[lv]      <= 1'b0;
        pend_chan[lv] <= '0;
      end else if (take[lv]) begin
        pend[lv] <= 1'b0;
      end else if (req[lv] && !pend[lv]) begin
        pend[lv]      <= 1'b1;
        pend_chan[lv] <= req_chan[lv];
      end
    end
  end

endmodule

// File: rtl/adc_irq_gate.sv
// Sticky completion flags and enable-gated interrupt outputs.
module adc_irq_gate #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_evt,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] ie,
  output logic [NSRC-1:0] flag,
  output logic [NSRC-1:0] irq
);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)          flag[s] <= 1'b0;
      else if (set_evt[s]) flag[s] <= 1'b1;
      else if (clr[s])     flag[s] <= 1'b0;
    end
    assign irq[s] = ie[s] & flag[s];
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_seq_pkg::*;
#(
  parameter int NCH = 32,
  parameter int DW  = 12,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_mask,
  input  logic           scan_start,
  input  logic           repeat_en,
  input  logic           force_stop,
  input  logic           prio1_req,
  input  logic [CHW-1:0] prio1_chan,
  input  logic           prio2_req,
  input  logic [CHW-1:0] prio2_chan,
  input  logic           scan_ie,
  input  logic           prio_ie,
  input  logic           scan_flag_clr,
  input  logic           prio_flag_clr,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  output logic           conv_abort,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  output logic           res_valid,
  output logic [DW-1:0]  res_data,
  output logic [CHW-1:0] res_chan,
  output logic [1:0]     res_src,
  output logic           scan_busy,
  output logic           prio_busy,
  output logic           prio_pend,
  output logic           scan_flag,
  output logic           prio_flag,
  output logic           scan_irq,
  output logic           prio_irq
);

  localparam int NLVL = 2;

  // Conversion in flight
  logic           active;
  src_e           act_src;
  logic [CHW-1:0] act_chan;
  logic [CHW:0]   scan_from;   // next scan index to search from

  // Channel picker
  logic           pick_found;
  logic [CHW-1:0] pick_idx;

  adc_chan_pick #(.NCH(NCH)) u_pick (
    .mask  (chan_mask),
    .from  (scan_from),
    .found (pick_found),
    .idx   (pick_idx)
  );

  // Priority holding; index 0 = level 1, index 1 = level 2
  logic [NLVL-1:0]          pend;
  logic [NLVL-1:0][CHW-1:0] pend_chan;
  logic [NLVL-1:0]          take;

  adc_prio_hold #(.NCH(NCH), .NLVL(NLVL)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (force_stop),
    .req       ({prio2_req, prio1_req}),
    .req_chan  ({prio2_chan, prio1_chan}),
    .take      (take),
    .pend      (pend),
    .pend_chan (pend_chan)
  );

  // Named events, also watched by the checker
  logic           boundary;
  logic           launch_l2, launch_l1, launch_scan, launch;
  logic           pass_end;
  logic           start_ok;
  logic           done_ok;
  logic           scan_set_evt, prio_set_evt;
  src_e           launch_src;
  logic [CHW-1:0] launch_chan;

  assign boundary    = !active && !force_stop;
  assign launch_l2   = boundary && pend[1];
  assign launch_l1   = boundary && !pend[1] && pend[0];
  assign launch_scan = boundary && !(|pend) && scan_busy && pick_found;
  assign pass_end    = boundary && !(|pend) && scan_busy && !pick_found;
  assign launch      = launch_l2 || launch_l1 || launch_scan;
  assign take        = {launch_l2, launch_l1};
  assign start_ok    = scan_start && !scan_busy && !force_stop;
  assign done_ok     = active && conv_done && !force_stop;

  always_comb begin
    launch_src  = SRC_SCAN;
    launch_chan = pick_idx;
    if (launch_l2) begin
      launch_src  = SRC_LV2;
      launch_chan = pend_chan[1];
    end else if (launch_l1) begin
      launch_src  = SRC_LV1;
      launch_chan = pend_chan[0];
    end
  end

  assign scan_set_evt = pass_end || (start_ok && !(|chan_mask));
  assign prio_set_evt = done_ok && (act_src != SRC_SCAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      act_src    <= SRC_SCAN;
      act_chan   <= '0;
      scan_from  <= '0;
      scan_busy  <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_chan   <= '0;
      res_src    <= 2'b00;
    end else begin
      conv_start <= 1'b0;
      res_valid  <= 1'b0;
      if (force_stop) begin
        active    <= 1'b0;
        scan_busy <= 1'b0;
      end else begin
        if (start_ok && (|chan_mask)) begin
          scan_busy <= 1'b1;
          scan_from <= '0;
        end
        if (done_ok) begin
          active    <= 1'b0;
          res_valid <= 1'b1;
          res_data  <= conv_data;
          res_chan  <= act_chan;
          res_src   <= act_src;
          if (act_src == SRC_SCAN) scan_from <= {1'b0, act_chan} + 1'b1;
        end
        if (launch) begin
          active     <= 1'b1;
          conv_start <= 1'b1;
          conv_chan  <= launch_chan;
          act_chan   <= launch_chan;
          act_src    <= launch_src;
        end
        if (pass_end) begin
          if (repeat_en) scan_from <= '0;
          else           scan_busy <= 1'b0;
        end
      end
    end
  end

  assign prio_busy  = active && (act_src != SRC_SCAN);
  assign prio_pend  = |pend;
  assign conv_abort = force_stop && active;

  logic [1:0] flags, irqs;

  adc_irq_gate #(.NSRC(2)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt ({prio_set_evt, scan_set_evt}),
    .clr     ({prio_flag_clr, scan_flag_clr}),
    .ie      ({prio_ie, scan_ie}),
    .flag    (flags),
    .irq     (irqs)
  );

  assign scan_flag = flags[0];
  assign prio_flag = flags[1];
  assign scan_irq  = irqs[0];
  assign prio_irq  = irqs[1];

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NCH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_mask,
  input logic           scan_start,
  input logic           force_stop,
  input logic           conv_start,
  input logic           scan_busy,
  input logic           prio_busy,
  input logic           prio_pend,
  input logic           scan_flag,
  input logic           scan_ie,
  input logic           scan_irq,
  input logic           prio_ie,
  input logic           prio_irq,
  input logic           launch_l1,
  input logic [1:0]     pend
);

  // R4
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_stop |=> (!scan_busy && !prio_busy && !prio_pend));

  // R6
  lv2_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_l1 |-> !pend[1]);

  // R7
  start_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (scan_busy || prio_busy));

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R8
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_start && !scan_busy && !force_stop && (chan_mask == '0))
      |=> (!scan_busy && scan_flag));

  // R9
  scan_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq |-> scan_ie);

  // R9
  prio_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prio_irq |-> prio_ie);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_mask  (chan_mask),
  .scan_start (scan_start),
  .force_stop (force_stop),
  .conv_start (conv_start),
  .scan_busy  (scan_busy),
  .prio_busy  (prio_busy),
  .prio_pend  (prio_pend),
  .scan_flag  (scan_flag),
  .scan_ie    (scan_ie),
  .scan_irq   (scan_irq),
  .prio_ie    (prio_ie),
  .prio_irq   (prio_irq),
  .launch_l1  (launch_l1),
  .pend       (pend)
);

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] chan_mask = '0;
  logic        scan_start = 0, repeat_en = 0, force_stop = 0;
  logic        prio1_req = 0, prio2_req = 0;
  logic [4:0]  prio1_chan = '0, prio2_chan = '0;
  logic        scan_ie = 0, prio_ie = 0, scan_flag_clr = 0, prio_flag_clr = 0;
  logic        conv_start, conv_abort, conv_done;
  logic [4:0]  conv_chan;
  logic [11:0] conv_data;
  logic        res_valid;
  logic [11:0] res_data;
  logic [4:0]  res_chan;
  logic [1:0]  res_src;
  logic        scan_busy, prio_busy, prio_pend, scan_flag, prio_flag, scan_irq, prio_irq;

  always #4 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .chan_mask(chan_mask), .scan_start(scan_start),
    .repeat_en(repeat_en), .force_stop(force_stop),
    .prio1_req(prio1_req), .prio1_chan(prio1_chan),
    .prio2_req(prio2_req), .prio2_chan(prio2_chan),
    .scan_ie(scan_ie), .prio_ie(prio_ie),
    .scan_flag_clr(scan_flag_clr), .prio_flag_clr(prio_flag_clr),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_abort(conv_abort),
    .conv_done(conv_done), .conv_data(conv_data),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan), .res_src(res_src),
    .scan_busy(scan_busy), .prio_busy(prio_busy), .prio_pend(prio_pend),
    .scan_flag(scan_flag), .prio_flag(prio_flag),
    .scan_irq(scan_irq), .prio_irq(prio_irq)
  );

  int vectors = 0;
  int errors  = 0;
  int got     = 0;

  function automatic logic [11:0] model_data(input logic [4:0] ch);
    return 12'((int'(ch) * 149 + 7) ^ 12'h2A5);
  endfunction

  // Behavioural converter
  int          cnt = 0;
  logic [4:0]  cur_ch = '0;
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (!rst_n) begin
      cnt <= 0;
      conv_data <= '0;
    end else if (conv_abort) begin
      cnt <= 0;
    end else if (conv_start) begin
      cnt <= LAT;
      cur_ch <= conv_chan;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        conv_done <= 1'b1;
        conv_data <= model_data(cur_ch);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard
  logic [18:0] exp_q[$];
  string       tag_q[$];

  task automatic push(input string req, input logic [1:0] src, input logic [4:0] ch);
    exp_q.push_back({src, ch, model_data(ch)});
    tag_q.push_back(req);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      got++;
      if (exp_q.size() == 0) begin
        vectors++; errors++;
        $display("FAIL R4 unexpected result: actual %0h expected none",
                 {res_src, res_chan, res_data});
      end else begin
        string t;
        logic [18:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {13'b0, res_src, res_chan, res_data}, {13'b0, e});
      end
    end
  end

  task automatic wait_got(input int n);
    for (int k = 0; k < 2000 && got < n; k++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && (scan_busy || prio_busy || prio_pend); k++) @(negedge clk);
    repeat (LAT + 3) @(negedge clk);
  endtask

  task automatic pulse_start();
    scan_start = 1; @(negedge clk); scan_start = 0;
  endtask

  task automatic clear_flags();
    scan_flag_clr = 1; prio_flag_clr = 1; @(negedge clk);
    scan_flag_clr = 0; prio_flag_clr = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    check("R7 reset busy", {30'b0, scan_busy, prio_busy}, 0);
    check("R9 reset irq", {30'b0, scan_irq, prio_irq}, 0);
    check("R1 reset valid", {31'b0, res_valid}, 0);

    // R8: empty mask
    scan_ie = 1;
    chan_mask = '0;
    pulse_start();
    check("R8 busy stays low", {31'b0, scan_busy}, 0);
    check("R8 flag set", {31'b0, scan_flag}, 1);
    check("R9 irq follows flag", {31'b0, scan_irq}, 1);
    repeat (8) @(negedge clk);
    check("R8 no conversion", got, 0);
    clear_flags();
    check("R9 flag cleared", {31'b0, scan_flag}, 0);

    // R1: sparse mask including both ends
    chan_mask = 32'h8002_0012;
    push("R1", 2'b00, 5'd1); push("R1", 2'b00, 5'd4);
    push("R1", 2'b00, 5'd17); push("R1", 2'b00, 5'd31);
    pulse_start();
    check("R1 busy", {31'b0, scan_busy}, 1);
    wait_idle();
    check("R1 all results", exp_q.size(), 0);
    check("R3 flag at end", {31'b0, scan_flag}, 1);
    scan_ie = 0; @(negedge clk);
    check("R9 gated off", {31'b0, scan_irq}, 0);
    clear_flags();

    // R5 R6 R7: priority cutting into a scan
    prio_ie = 1;
    chan_mask = 32'h0000_0224;  // channels 2,5,9
    push("R1 R5", 2'b00, 5'd2);
    push("R6 level2 first", 2'b10, 5'd7);
    push("R6 level1 next", 2'b01, 5'd3);
    push("R5 resume", 2'b00, 5'd5);
    push("R5 resume", 2'b00, 5'd9);
    got = 0;
    pulse_start();
    for (int k = 0; k < 50 && !conv_start; k++) @(negedge clk);
    check("R1 first chan", {27'b0, conv_chan}, 2);
    prio2_req = 1; prio2_chan = 5'd7; prio1_req = 1; prio1_chan = 5'd3;
    @(negedge clk);
    prio2_req = 0; prio1_req = 0;
    check("R5 pending", {31'b0, prio_pend}, 1);
    for (int k = 0; k < 50 && !prio_busy; k++) @(negedge clk);
    check("R7 prio busy", {31'b0, prio_busy}, 1);
    check("R6 level2 chan", {27'b0, conv_chan}, 7);
    check("R7 scan still busy", {31'b0, scan_busy}, 1);
    wait_idle();
    check("R5 all results", exp_q.size(), 0);
    check("R9 prio irq", {31'b0, prio_irq}, 1);
    clear_flags();
    check("R9 prio cleared", {31'b0, prio_irq}, 0);

    // R2 R3: repeat, then clear it mid-pass
    chan_mask = 32'h0000_0009;  // channels 0,3
    repeat_en = 1;
    push("R2", 2'b00, 5'd0); push("R2", 2'b00, 5'd3);
    push("R2 wrap", 2'b00, 5'd0); push("R3 finish pass", 2'b00, 5'd3);
    got = 0;
    pulse_start();
    wait_got(3);
    check("R2 busy after wrap", {31'b0, scan_busy}, 1);
    repeat_en = 0;
    wait_idle();
    check("R3 stopped", {31'b0, scan_busy}, 0);
    check("R3 results", exp_q.size(), 0);
    check("R3 result count", got, 4);
    check("R3 flag", {31'b0, scan_flag}, 1);
    clear_flags();

    // R4: forced stop mid-scan with a pending request
    chan_mask = 32'hFFFF_FFFF;
    push("R4", 2'b00, 5'd0); push("R4", 2'b00, 5'd1);
    got = 0;
    pulse_start();
    wait_got(2);
    prio1_req = 1; prio1_chan = 5'd4;
    @(negedge clk);
    prio1_req = 0;
    check("R4 pending before stop", {31'b0, prio_pend}, 1);
    force_stop = 1;
    @(negedge clk);
    force_stop = 0;
    check("R4 scan busy cleared", {31'b0, scan_busy}, 0);
    check("R4 prio cleared", {30'b0, prio_busy, prio_pend}, 0);
    repeat (20) @(negedge clk);
    check("R4 no further results", got, 2);
    check("R4 queue", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule